// File: doc/BRIEF.md
# Frame Quality Rejection Filter

This block inspects a stream of corrected detector pixels and decides, for every frame, whether the frame holds enough bright spots to be worth keeping. A pixel brighter than a programmable level counts as a candidate diffraction peak. The block keeps one peak count for each quadrant of the frame and one for the frame as a whole. When the last pixel of a frame has passed, it issues a one-cycle verdict with a keep flag and all five counts. Most frames are expected to be thrown away, so the verdict follows the frame's last pixel with no extra latency.

The decision can use the whole-frame count or the four quadrant counts. In quadrant mode, a policy input chooses how the quadrants combine. Under the lenient policy, one quadrant that reaches the minimum is enough to keep the frame. Under the strict policy, all four quadrants must reach it. The frame size is fixed by parameters. The first pixel of a frame carries a start marker and the last pixel of each row carries an end-of-line marker. Storing or dropping the frame data is left to downstream logic.

Top module: `frame_reject_filter`

## Requirements
- R1: A valid pixel is a peak only when `pix_data` is strictly greater than the threshold in force for its frame. A pixel equal to the threshold is not a peak.
- R2: Quadrant membership compares the pixel's row with FRAME_H/2 and its column with FRAME_W/2. Quadrant 0 is top-left, 1 is top-right, 2 is bottom-left and 3 is bottom-right. Quadrant k's count sits at `quad_counts[k*CNT_W +: CNT_W]`.
- R3: Every count saturates at 2^CNT_W-1 and never wraps.
- R4: All counts restart on a valid pixel carrying `pix_sof`, and that first pixel is counted in the new frame.
- R5: `verdict_valid` is a single-cycle pulse in the cycle after the frame's last pixel, which is the valid pixel with `pix_eol` in row FRAME_H-1. The counts stay valid alongside the pulse and are held until the next frame starts.
- R6: With `cfg_quad_mode`=0, the frame is kept when the whole-frame count is at least the minimum.
- R7: With `cfg_quad_mode`=1 and `cfg_all_quads`=0, the frame is kept when at least one quadrant count is at least the minimum.
- R8: With `cfg_quad_mode`=1 and `cfg_all_quads`=1, the frame is kept only when all four quadrant counts are at least the minimum.
- R9: The threshold, minimum, mode and policy are captured on the start-of-frame pixel. Changing them later in the frame has no effect on that frame.
- R10: After reset, `verdict_valid`, `verdict_keep` and all counts are zero.
- R11: Cycles with `pix_valid` low have no effect, whatever the values of the data and marker inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| pix_data | input | PIX_W | Corrected pixel intensity |
| cfg_threshold | input | PIX_W | Peak intensity level |
| cfg_min_peaks | input | CNT_W | Minimum peak count for keeping a frame |
| cfg_quad_mode | input | 1 | 0 = whole frame, 1 = per quadrant |
| cfg_all_quads | input | 1 | Quadrant policy: 0 = any quadrant, 1 = all quadrants |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_keep | output | 1 | Keep flag, qualified by the strobe |
| frame_count | output | CNT_W | Whole-frame peak count |
| quad_counts | output | 4*CNT_W | Four quadrant peak counts |

## Verification
Some properties are checked on every cycle by the assertions:
- the counts never wrap once saturated;
- the counts restart on a start-of-frame pixel;
- the counts stay still when no peak arrives;
- the configuration stays frozen inside a frame;
- the verdict is a one-cycle pulse that follows the last pixel.

Other behaviour only the bench's scenarios can show:
- the correct quadrant mapping;
- the strict comparison against the threshold;
- the three keep rules;
- that idle cycles and mid-frame configuration changes leave the counts and verdict untouched.

The bench checks these against counts that it derives itself from each frame's pixel pattern.

// File: rtl/frf_pkg.sv
package frf_pkg;
  localparam int unsigned NQ = 4;

  typedef enum logic [1:0] {
    Q_TOP_LEFT  = 2'd0,
    Q_TOP_RIGHT = 2'd1,
    Q_BOT_LEFT  = 2'd2,
    Q_BOT_RIGHT = 2'd3
  } quad_e;

  // Lower half selects bit 1, right half selects bit 0.
  function automatic quad_e quad_of(input logic lower, input logic right);
    return quad_e'({lower, right});
  endfunction
endpackage

// File: rtl/frf_position.sv
module frf_position #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned FRAME_H = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic                sof,
  input  logic                eol,
  output frf_pkg::quad_e      quad,
  output logic                last_pix
);
  localparam int unsigned CW     = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int unsigned RW     = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
  localparam int unsigned HALF_W = FRAME_W / 2;
  localparam int unsigned HALF_H = FRAME_H / 2;

  logic [CW-1:0] col_q, cur_col;
  logic [RW-1:0] row_q, cur_row;

  // The start marker forces the position back to the origin.
  assign cur_col = sof ? '0 : col_q;
  assign cur_row = sof ? '0 : row_q;

  assign quad = frf_pkg::quad_of(cur_row >= RW'(HALF_H), cur_col >= CW'(HALF_W));
  assign last_pix = valid && eol && (cur_row == RW'(FRAME_H - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid) begin
      if (eol) begin
        col_q <= '0;
        row_q <= cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/frf_sat_counter.sv
module frf_sat_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? CMAX : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= inc ? CNT_W'(1) : '0;
    else if (inc) count <= sat_step(count);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CMAX) |=> (count == CMAX)); // R3
  AST_CLEAR_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count <= CNT_W'(1))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count)); // R11
endmodule

// File: rtl/frf_verdict.sv
module frf_verdict #(
  parameter int unsigned CNT_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           last_pix,
  input  logic [frf_pkg::NQ*CNT_W-1:0]   qcnt,
  input  logic [CNT_W-1:0]               total,
  input  logic [CNT_W-1:0]               min_peaks,
  input  logic                           quad_mode,
  input  logic                           all_quads,
  output logic                           verdict_valid,
  output logic                           verdict_keep
);
  function automatic logic meets(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return c >= m;
  endfunction

  logic [frf_pkg::NQ-1:0] q_ok;
  logic                   keep_raw;

  for (genvar k = 0; k < frf_pkg::NQ; k++) begin : g_qok
    assign q_ok[k] = meets(qcnt[k*CNT_W +: CNT_W], min_peaks);
  end

  always_comb begin
    if (!quad_mode)    keep_raw = meets(total, min_peaks);
    else if (all_quads) keep_raw = &q_ok;
    else               keep_raw = |q_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_valid <= 1'b0;
    else        verdict_valid <= last_pix;
  end

  assign verdict_keep = verdict_valid & keep_raw;

  AST_VERDICT_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_pix |=> verdict_valid); // R5
  AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid); // R5
  AST_KEEP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !verdict_keep); // R10
endmodule

// File: rtl/frame_reject_filter.sv
module frame_reject_filter #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned FRAME_H = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pix_valid,
  input  logic                          pix_sof,
  input  logic                          pix_eol,
  input  logic [PIX_W-1:0]              pix_data,
  input  logic [PIX_W-1:0]              cfg_threshold,
  input  logic [CNT_W-1:0]              cfg_min_peaks,
  input  logic                          cfg_quad_mode,
  input  logic                          cfg_all_quads,
  output logic                          verdict_valid,
  output logic                          verdict_keep,
  output logic [CNT_W-1:0]              frame_count,
  output logic [frf_pkg::NQ*CNT_W-1:0]  quad_counts
);
  function automatic logic is_peak(input logic [PIX_W-1:0] v, input logic [PIX_W-1:0] thr);
    return v > thr;
  endfunction

  frf_pkg::quad_e         quad;
  logic                   last_pix;
  logic                   frame_start;
  logic                   peak_hit;
  logic [frf_pkg::NQ-1:0] quad_hit;
  logic [PIX_W-1:0]       thr_q, thr_now;
  logic [CNT_W-1:0]       min_q;
  logic                   qmode_q, allq_q;

  assign frame_start = pix_valid & pix_sof;
  // The start pixel is judged with the threshold arriving alongside it.
  assign thr_now  = pix_sof ? cfg_threshold : thr_q;
  assign peak_hit = pix_valid && is_peak(pix_data, thr_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      min_q   <= '0;
      qmode_q <= 1'b0;
      allq_q  <= 1'b0;
    end else if (frame_start) begin
      thr_q   <= cfg_threshold;
      min_q   <= cfg_min_peaks;
      qmode_q <= cfg_quad_mode;
      allq_q  <= cfg_all_quads;
    end
  end

  frf_position #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_pos (
    .clk(clk), .rst_n(rst_n), .valid(pix_valid), .sof(pix_sof), .eol(pix_eol),
    .quad(quad), .last_pix(last_pix)
  );

  for (genvar k = 0; k < frf_pkg::NQ; k++) begin : g_quad
    assign quad_hit[k] = peak_hit && (quad == frf_pkg::quad_e'(k));
    frf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(quad_hit[k]),
      .count(quad_counts[k*CNT_W +: CNT_W])
    );
  end

  frf_sat_counter #(.CNT_W(CNT_W)) u_total (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(peak_hit), .count(frame_count)
  );

  frf_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk(clk), .rst_n(rst_n), .last_pix(last_pix), .qcnt(quad_counts),
    .total(frame_count), .min_peaks(min_q), .quad_mode(qmode_q), .all_quads(allq_q),
    .verdict_valid(verdict_valid), .verdict_keep(verdict_keep)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(thr_q) && $stable(min_q) && $stable(qmode_q) && $stable(allq_q))); // R9
  AST_ONE_QUADRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(quad_hit)); // R2
endmodule

// File: tb/frame_reject_filter_bench.sv
module frame_reject_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8, CW = 4, FW = 8, FH = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
  logic [PW-1:0] pix_data = '0, cfg_threshold = '0;
  logic [CW-1:0] cfg_min_peaks = '0;
  logic cfg_quad_mode = 1'b0, cfg_all_quads = 1'b0;
  logic verdict_valid, verdict_keep;
  logic [CW-1:0] frame_count;
  logic [4*CW-1:0] quad_counts;

  frame_reject_filter #(.PIX_W(PW), .CNT_W(CW), .FRAME_W(FW), .FRAME_H(FH)) u_frame_reject_filter (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .pix_data(pix_data), .cfg_threshold(cfg_threshold), .cfg_min_peaks(cfg_min_peaks),
    .cfg_quad_mode(cfg_quad_mode), .cfg_all_quads(cfg_all_quads),
    .verdict_valid(verdict_valid), .verdict_keep(verdict_keep),
    .frame_count(frame_count), .quad_counts(quad_counts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic       keep;
    logic [3:0] q0, q1, q2, q3, tot;
    int         cyc;
    logic [3:0] req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit prev_valid = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pix_val(input int kind, input int r, input int c);
    case (kind)
      0: return 0;
      1: return (r < FH/2 && c < FW/2) ? 100 : 5;
      2: return 200;
      3: return ((r*FW + c) * 3) & 8'hFF;
      4: return ((r + c) % 2 == 1) ? 50 : 0;
      default: return (r == FH-1 && c >= FW/2) ? 60 : 1;
    endcase
  endfunction

  // Driver: computes the expected verdict, then drives the frame.
  task automatic send_frame(input int kind, input int thr, input int minp, input bit qm,
                            input bit aq, input bit gaps, input bit poke, input int reqtag);
    exp_t e;
    int q[4];
    int tot;
    bit ok_any, ok_all, keep;
    q = '{0, 0, 0, 0};
    tot = 0;
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++)
        if (pix_val(kind, r, c) > thr) begin
          int k;
          k = ((r >= FH/2) ? 2 : 0) + ((c >= FW/2) ? 1 : 0);
          if (q[k] < CMAX) q[k]++;
          if (tot < CMAX) tot++;
        end
    ok_any = 0; ok_all = 1;
    for (int k = 0; k < 4; k++) begin
      ok_any |= (q[k] >= minp);
      ok_all &= (q[k] >= minp);
    end
    keep = !qm ? (tot >= minp) : (aq ? ok_all : ok_any);
    e.keep = keep; e.q0 = 4'(q[0]); e.q1 = 4'(q[1]); e.q2 = 4'(q[2]); e.q3 = 4'(q[3]);
    e.tot = 4'(tot); e.req = 4'(reqtag);
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++) begin
        if (gaps && c == 3) begin
          @(negedge clk);
          pix_valid = 0; pix_data = 8'hFF; pix_sof = 1; pix_eol = 1;
        end
        @(negedge clk);
        pix_valid = 1;
        pix_sof = (r == 0 && c == 0);
        pix_eol = (c == FW-1);
        pix_data = PW'(pix_val(kind, r, c));
        if (r == 0 && c == 0) begin
          cfg_threshold = PW'(thr); cfg_min_peaks = CW'(minp);
          cfg_quad_mode = qm; cfg_all_quads = aq;
        end
        if (poke && r == 2 && c == 0) begin
          cfg_threshold = 0; cfg_min_peaks = 4'd15;
          cfg_quad_mode = ~qm; cfg_all_quads = ~aq;
        end
        if (r == FH-1 && c == FW-1) begin
          e.cyc = cyc;
          exp_q.push_back(e);
        end
      end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 0; pix_sof = 0; pix_eol = 0;
    end
  endtask

  function automatic string rname(input logic [3:0] t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Monitor: pops one expected verdict per strobe and compares.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid && verdict_valid) chk(0, "R5 pulse width", 2, 1);
      prev_valid = verdict_valid;
      if (verdict_valid) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected verdict", 1, 0);
        else begin
          exp_t e;
          string tg;
          e = exp_q.pop_front();
          tg = rname(e.req);
          chk(cyc == e.cyc + 1, "R5 verdict timing", cyc, e.cyc + 1);
          chk(verdict_keep == e.keep, {tg, " keep"}, verdict_keep, e.keep);
          chk(quad_counts[3:0] == e.q0, {tg, " R2 quad0"}, quad_counts[3:0], e.q0);
          chk(quad_counts[7:4] == e.q1, {tg, " R2 quad1"}, quad_counts[7:4], e.q1);
          chk(quad_counts[11:8] == e.q2, {tg, " R2 quad2"}, quad_counts[11:8], e.q2);
          chk(quad_counts[15:12] == e.q3, {tg, " R2 quad3"}, quad_counts[15:12], e.q3);
          chk(frame_count == e.tot, {tg, " total"}, frame_count, e.tot);
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(verdict_valid == 0, "R10 valid", verdict_valid, 0);
    chk(verdict_keep == 0, "R10 keep", verdict_keep, 0);
    chk(frame_count == 0, "R10 total", frame_count, 0);
    chk(quad_counts == 0, "R10 quads", quad_counts, 0);
    rst_n = 1;
    idle(2);
    send_frame(1, 50, 3, 0, 0, 0, 0, 6);   // R6 whole frame, top-left peaks only
    idle(3);
    send_frame(1, 50, 3, 1, 0, 0, 0, 7);   // R7 any quadrant keeps
    idle(3);
    send_frame(1, 50, 3, 1, 1, 0, 0, 8);   // R8 all quadrants reject
    idle(3);
    send_frame(0, 0, 1, 0, 0, 0, 0, 6);    // R6 empty frame rejected
    send_frame(2, 10, 15, 1, 1, 0, 0, 3);  // R3 saturation, back to back (R4)
    send_frame(3, 90, 5, 1, 0, 0, 0, 1);   // R1 value equal to threshold not counted
    send_frame(5, 30, 4, 0, 0, 0, 0, 4);   // R4 counts restart after saturated frame
    idle(2);
    send_frame(4, 40, 8, 1, 1, 1, 1, 9);   // R9 mid-frame config change, R11 gaps
    idle(2);
    send_frame(4, 40, 8, 0, 0, 1, 0, 11);  // R11 idle cycles with markers ignored
    idle(2);
    send_frame(3, 120, 9, 1, 1, 0, 0, 8);  // R8 bottom-heavy pattern
    idle(2);
    send_frame(5, 30, 0, 1, 1, 0, 0, 8);   // R8 zero minimum keeps
    idle(5);
    chk(exp_q.size() == 0, "R5 missing verdicts", exp_q.size(), 0);
    finish_run();
  end
endmodule